// File: doc/BRIEF.md
# Multichannel Controller Action Decoder

This block decodes the 32-bit action word that a host writes into a multichannel serial controller. It carries out the initialization that the word asks for, using a word-addressed configuration memory. One action can do several things. It can define where the interrupt queue lives and how long it is. It can reload the 32-entry timeslot table. It can reload the specification of one channel. It can also reset, which reloads the timeslot table and every channel. Each reloaded channel seeds its current receive and transmit pointers and stores its transmit pointer back into a fixed area of configuration memory.

The block reads one configuration word per cycle. Read data arrives one cycle after the address. `busy` is high while a sequence runs, and a host write arriving in that time is dropped. When a load action finishes, the block raises `ack_post` for one cycle unless the action word masked it. A neighbouring interrupt-queue writer uses that pulse to post an acknowledge word with bit 15 set. The tables are read combinationally through two select ports, for use by the channel engines.

Top module: `mcad_action_decoder`

## Requirements
- R1: Action bit 2 loads `iq_base` and `iq_cur` from configuration word 1 (byte offset 0x04). It sets `iq_len` to (bits 7:0 of word 2 plus 1) times 16, counted in words.
- R2: Action bit 15 reloads timeslot entry i from configuration word 3+i for all 32 entries. It also reloads the one channel whose number is in action bits 12:8. No other channel changes.
- R3: Action bit 14 reloads only the channel given in bits 12:8. The timeslot table and the other channels keep their values.
- R4: Action bit 6 reloads all 32 timeslot entries and all 32 channels.
- R5: Channel c is loaded from words 35+4c to 38+4c. These words are, in order: status, first receive descriptor address, first transmit descriptor address and buffer-size word. The current receive pointer takes the first receive address, and the current transmit pointer takes the first transmit address.
- R6: For each loaded channel c, the block writes the first transmit address to configuration word 195+c (byte offset 0x30C+4c). It makes exactly one write per loaded channel and no other write.
- R7: After an action with bit 15, 14 or 6 set, `ack_post` is high for exactly one cycle at the end of the sequence, provided action bit 7 is 0. There is no pulse when bit 7 is 1, and none for an action that only has bit 2 set.
- R8: When bit 2 is combined with a load bit, the two queue words are read before any table word.
- R9: An accepted write makes `busy` high from the next cycle until the sequence ends. The block makes at most one configuration access per cycle. A write to `act_wr` while `busy` is high is ignored. An action with none of bits 2, 6, 14 and 15 set holds `busy` high for one cycle and touches nothing.
- R10: In an illegal word that combines load bits, bit 6 wins over bit 15, and bit 15 wins over bit 14. Only one acknowledge is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_wr | input | 1 | Host write strobe for the action word |
| act_wdata | input | 32 | Action word |
| busy | output | 1 | Sequence in progress; writes are ignored |
| cfg_rd | output | 1 | Configuration memory read enable |
| cfg_wr | output | 1 | Configuration memory write enable |
| cfg_addr | output | 16 | Configuration word address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid one cycle after the read |
| iq_base | output | 32 | Interrupt queue base address |
| iq_cur | output | 32 | Interrupt queue current pointer |
| iq_len | output | 13 | Interrupt queue length in words |
| ack_post | output | 1 | One-cycle acknowledge-post request |
| ts_sel | input | 5 | Timeslot entry select |
| ts_word | output | 32 | Selected timeslot entry |
| ch_sel | input | 5 | Channel select |
| ch_status | output | 32 | Selected channel status word |
| ch_rx_first | output | 32 | Selected channel first receive descriptor address |
| ch_tx_first | output | 32 | Selected channel first transmit descriptor address |
| ch_bufsz | output | 32 | Selected channel buffer-size word |
| ch_rx_cur | output | 32 | Selected channel current receive pointer |
| ch_tx_cur | output | 32 | Selected channel current transmit pointer |

## Verification
The assertions are checked on every cycle. They cover these properties:
- `busy` rises after an accepted write, and the latched action stays the same while writes arrive during a sequence.
- A read and a write never share a cycle, and every write lands in the transmit-pointer area.
- The acknowledge pulse lasts one cycle and comes only in a quiet final cycle.
- A captured transmit address seeds the current pointer, and a captured queue base sets the current queue pointer.

Other behaviour shows only in the bench scenarios, which compare the table contents against a memory model:
- which words are fetched, and in what order;
- which channels change and which keep their values;
- the computed queue length at its limits;
- the priority among illegal bit combinations;
- the dropping of an intruding write.

// File: rtl/mcad_pkg.sv
package mcad_pkg;

    parameter int DW      = 32;
    parameter int CFG_AW  = 16;
    parameter int NUM_TS  = 32;
    parameter int NUM_CH  = 32;
    parameter int CH_W    = $clog2(NUM_CH);
    parameter int TS_W    = $clog2(NUM_TS);
    parameter int IQ_SZ_W = 13;

    // word offsets inside configuration memory
    parameter int W_IQ_BASE = 1;
    parameter int W_IQ_LEN  = 2;
    parameter int W_TS0     = 3;
    parameter int W_CH0     = 35;
    parameter int CH_WORDS  = 4;
    parameter int W_TXP0    = 195;

    // action word bit positions
    parameter int B_IQDEF = 2;
    parameter int B_RESET = 6;
    parameter int B_MASK  = 7;
    parameter int B_CHSEL = 8;
    parameter int B_CHONE = 14;
    parameter int B_INIT  = 15;

    typedef enum logic [2:0] {
        PH_IDLE, PH_IQ, PH_TS, PH_CH, PH_WB, PH_DONE
    } phase_t;

    typedef enum logic [1:0] {
        K_IQ, K_TS, K_CH
    } kind_t;

    typedef struct packed {
        logic            valid;
        kind_t           kind;
        logic [CH_W-1:0] ch;
        logic [TS_W-1:0] idx;
    } rd_tag_t;

    typedef struct packed {
        logic            iq;
        logic            ts;
        logic            ch_one;
        logic            ch_all;
        logic            ack;
        logic [CH_W-1:0] ch;
    } act_t;

    typedef struct packed {
        logic [DW-1:0] status;
        logic [DW-1:0] rx_first;
        logic [DW-1:0] tx_first;
        logic [DW-1:0] bufsz;
        logic [DW-1:0] rx_cur;
        logic [DW-1:0] tx_cur;
    } chan_t;

    function automatic act_t decode_act(input logic [DW-1:0] w);
        act_t a;
        a.iq     = w[B_IQDEF];
        a.ts     = w[B_INIT] | w[B_RESET];
        a.ch_all = w[B_RESET];
        a.ch_one = (w[B_INIT] | w[B_CHONE]) & ~w[B_RESET];
        a.ack    = (w[B_INIT] | w[B_CHONE] | w[B_RESET]) & ~w[B_MASK];
        a.ch     = w[B_CHSEL +: CH_W];
        return a;
    endfunction

    function automatic logic [IQ_SZ_W-1:0] iq_len_words(input logic [7:0] b);
        logic [IQ_SZ_W-1:0] n;
        n = IQ_SZ_W'(b) + IQ_SZ_W'(1);
        return n << 4;
    endfunction

endpackage

// File: rtl/mcad_seq.sv
module mcad_seq
    import mcad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act_wr,
    input  logic [DW-1:0]     act_wdata,
    output logic              busy,
    output logic              cfg_rd,
    output logic              cfg_wr,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic              ack_post,
    output rd_tag_t           tag,
    output logic [CH_W-1:0]   wb_ch
);

    phase_t          ph;
    act_t            act_q;
    logic [CH_W-1:0] ch_q;
    logic [TS_W-1:0] idx_q;
    act_t            act_d;

    assign act_d = decode_act(act_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            act_q <= '0;
            ch_q  <= '0;
            idx_q <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (act_wr) begin
                        act_q <= act_d;
                        ch_q  <= act_d.ch_all ? '0 : act_d.ch;
                        idx_q <= '0;
                        if (act_d.iq)          ph <= PH_IQ;
                        else if (act_d.ts)     ph <= PH_TS;
                        else if (act_d.ch_one) ph <= PH_CH;
                        else                   ph <= PH_DONE;
                    end
                end
                PH_IQ: begin
                    if (idx_q == TS_W'(1)) begin
                        idx_q <= '0;
                        if (act_q.ts)          ph <= PH_TS;
                        else if (act_q.ch_one) ph <= PH_CH;
                        else                   ph <= PH_DONE;
                    end else begin
                        idx_q <= idx_q + TS_W'(1);
                    end
                end
                PH_TS: begin
                    if (idx_q == TS_W'(NUM_TS - 1)) begin
                        idx_q <= '0;
                        ph    <= PH_CH;
                    end else begin
                        idx_q <= idx_q + TS_W'(1);
                    end
                end
                PH_CH: begin
                    if (idx_q == TS_W'(CH_WORDS - 1)) begin
                        idx_q <= '0;
                        ph    <= PH_WB;
                    end else begin
                        idx_q <= idx_q + TS_W'(1);
                    end
                end
                PH_WB: begin
                    if (act_q.ch_all && ch_q != CH_W'(NUM_CH - 1)) begin
                        ch_q <= ch_q + CH_W'(1);
                        ph   <= PH_CH;
                    end else begin
                        ph <= PH_DONE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cfg_addr = '0;
        tag      = '0;
        case (ph)
            PH_IQ: begin
                cfg_addr = CFG_AW'(W_IQ_BASE) + CFG_AW'(idx_q);
                tag.kind = K_IQ;
            end
            PH_TS: begin
                cfg_addr = CFG_AW'(W_TS0) + CFG_AW'(idx_q);
                tag.kind = K_TS;
            end
            PH_CH: begin
                cfg_addr = CFG_AW'(W_CH0) + (CFG_AW'(ch_q) << 2) + CFG_AW'(idx_q);
                tag.kind = K_CH;
            end
            PH_WB: cfg_addr = CFG_AW'(W_TXP0) + CFG_AW'(ch_q);
            default: cfg_addr = '0;
        endcase
        tag.valid = cfg_rd;
        tag.ch    = ch_q;
        tag.idx   = idx_q;
    end

    assign busy     = (ph != PH_IDLE);
    assign cfg_rd   = (ph == PH_IQ) || (ph == PH_TS) || (ph == PH_CH);
    assign cfg_wr   = (ph == PH_WB);
    assign ack_post = (ph == PH_DONE) && act_q.ack;
    assign wb_ch    = ch_q;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && act_wr) |=> busy); // R9
    AST_WRITE_IN_BUSY_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (busy && act_wr) |=> $stable(act_q)); // R9
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(cfg_rd && cfg_wr)); // R9
    AST_WB_AREA: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> (cfg_addr >= CFG_AW'(W_TXP0) && cfg_addr < CFG_AW'(W_TXP0 + NUM_CH))); // R6
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        ack_post |-> (busy && !cfg_rd && !cfg_wr)); // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_post |=> !ack_post); // R7

endmodule

// File: rtl/mcad_tables.sv
module mcad_tables
    import mcad_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rd_tag_t         tag,
    input  logic [DW-1:0]   cfg_rdata,
    input  logic [TS_W-1:0] ts_sel,
    input  logic [CH_W-1:0] ch_sel,
    input  logic [CH_W-1:0] wb_ch,
    output logic [DW-1:0]   ts_word,
    output chan_t           ch_view,
    output logic [DW-1:0]   wb_tx
);

    rd_tag_t       tag_q;
    logic [DW-1:0] ts_arr [NUM_TS];
    chan_t         ch_arr [NUM_CH];

    always_ff @(posedge clk) begin
        if (rst) tag_q <= '0;
        else     tag_q <= tag;
    end

    for (genvar t = 0; t < NUM_TS; t++) begin : g_ts
        logic [DW-1:0] ent;
        always_ff @(posedge clk) begin
            if (rst)
                ent <= '0;
            else if (tag_q.valid && tag_q.kind == K_TS && tag_q.idx == TS_W'(t))
                ent <= cfg_rdata;
        end
        assign ts_arr[t] = ent;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_t ent;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (tag_q.valid && tag_q.kind == K_CH && tag_q.ch == CH_W'(c)) begin
                case (tag_q.idx[1:0])
                    2'd0: ent.status <= cfg_rdata;
                    2'd1: begin
                        ent.rx_first <= cfg_rdata;
                        ent.rx_cur   <= cfg_rdata;
                    end
                    2'd2: begin
                        ent.tx_first <= cfg_rdata;
                        ent.tx_cur   <= cfg_rdata;
                    end
                    default: ent.bufsz <= cfg_rdata;
                endcase
            end
        end
        assign ch_arr[c] = ent;
    end

    assign ts_word = ts_arr[ts_sel];
    assign ch_view = ch_arr[ch_sel];
    assign wb_tx   = ch_arr[wb_ch].tx_first;

    AST_TXCUR_SEEDED: assert property (@(posedge clk) disable iff (rst)
        (tag_q.valid && tag_q.kind == K_CH && tag_q.idx == TS_W'(2))
        |=> ch_arr[$past(tag_q.ch)].tx_cur == $past(cfg_rdata)); // R5
    AST_RXCUR_SEEDED: assert property (@(posedge clk) disable iff (rst)
        (tag_q.valid && tag_q.kind == K_CH && tag_q.idx == TS_W'(1))
        |=> ch_arr[$past(tag_q.ch)].rx_cur == $past(cfg_rdata)); // R5

endmodule

// File: rtl/mcad_iq.sv
module mcad_iq
    import mcad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  rd_tag_t            tag,
    input  logic [DW-1:0]      cfg_rdata,
    output logic [DW-1:0]      iq_base,
    output logic [DW-1:0]      iq_cur,
    output logic [IQ_SZ_W-1:0] iq_len
);

    rd_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q   <= '0;
            iq_base <= '0;
            iq_cur  <= '0;
            iq_len  <= '0;
        end else begin
            tag_q <= tag;
            if (tag_q.valid && tag_q.kind == K_IQ) begin
                if (tag_q.idx == TS_W'(0)) begin
                    iq_base <= cfg_rdata;
                    iq_cur  <= cfg_rdata;
                end else begin
                    iq_len <= iq_len_words(cfg_rdata[7:0]);
                end
            end
        end
    end

    AST_IQ_CUR_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (rst)
        (tag_q.valid && tag_q.kind == K_IQ && tag_q.idx == TS_W'(0))
        |=> (iq_cur == iq_base && iq_base == $past(cfg_rdata))); // R1

endmodule

// File: rtl/mcad_action_decoder.sv
module mcad_action_decoder
    import mcad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               act_wr,
    input  logic [DW-1:0]      act_wdata,
    output logic               busy,
    output logic               cfg_rd,
    output logic               cfg_wr,
    output logic [CFG_AW-1:0]  cfg_addr,
    output logic [DW-1:0]      cfg_wdata,
    input  logic [DW-1:0]      cfg_rdata,
    output logic [DW-1:0]      iq_base,
    output logic [DW-1:0]      iq_cur,
    output logic [IQ_SZ_W-1:0] iq_len,
    output logic               ack_post,
    input  logic [TS_W-1:0]    ts_sel,
    output logic [DW-1:0]      ts_word,
    input  logic [CH_W-1:0]    ch_sel,
    output logic [DW-1:0]      ch_status,
    output logic [DW-1:0]      ch_rx_first,
    output logic [DW-1:0]      ch_tx_first,
    output logic [DW-1:0]      ch_bufsz,
    output logic [DW-1:0]      ch_rx_cur,
    output logic [DW-1:0]      ch_tx_cur
);

    rd_tag_t         tag;
    logic [CH_W-1:0] wb_ch;
    chan_t           ch_view;

    mcad_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .act_wr    (act_wr),
        .act_wdata (act_wdata),
        .busy      (busy),
        .cfg_rd    (cfg_rd),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .ack_post  (ack_post),
        .tag       (tag),
        .wb_ch     (wb_ch)
    );

    mcad_tables u_tables (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .cfg_rdata (cfg_rdata),
        .ts_sel    (ts_sel),
        .ch_sel    (ch_sel),
        .wb_ch     (wb_ch),
        .ts_word   (ts_word),
        .ch_view   (ch_view),
        .wb_tx     (cfg_wdata)
    );

    mcad_iq u_iq (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .cfg_rdata (cfg_rdata),
        .iq_base   (iq_base),
        .iq_cur    (iq_cur),
        .iq_len    (iq_len)
    );

    assign ch_status   = ch_view.status;
    assign ch_rx_first = ch_view.rx_first;
    assign ch_tx_first = ch_view.tx_first;
    assign ch_bufsz    = ch_view.bufsz;
    assign ch_rx_cur   = ch_view.rx_cur;
    assign ch_tx_cur   = ch_view.tx_cur;

endmodule

// File: tb/test_mcad_action_decoder.sv
module test_mcad_action_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        act_wr = 1'b0;
    logic [31:0] act_wdata = '0;
    logic        busy, cfg_rd, cfg_wr, ack_post;
    logic [15:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;
    logic [31:0] iq_base, iq_cur;
    logic [12:0] iq_len;
    logic [4:0]  ts_sel = '0;
    logic [4:0]  ch_sel = '0;
    logic [31:0] ts_word, ch_status, ch_rx_first, ch_tx_first, ch_bufsz, ch_rx_cur, ch_tx_cur;

    always #10 clk = ~clk;

    mcad_action_decoder i_mcad_action_decoder (
        .clk(clk), .rst(rst), .act_wr(act_wr), .act_wdata(act_wdata), .busy(busy),
        .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .iq_base(iq_base), .iq_cur(iq_cur), .iq_len(iq_len),
        .ack_post(ack_post), .ts_sel(ts_sel), .ts_word(ts_word), .ch_sel(ch_sel),
        .ch_status(ch_status), .ch_rx_first(ch_rx_first), .ch_tx_first(ch_tx_first),
        .ch_bufsz(ch_bufsz), .ch_rx_cur(ch_rx_cur), .ch_tx_cur(ch_tx_cur)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] seed = 16'h0000;
    logic [7:0]  iq_lo = 8'h00;
    int          rd_cnt = 0, wr_cnt = 0, ack_cnt = 0, oob_cnt = 0;
    logic [15:0] rd_log [1024];
    logic [31:0] wmem [256];
    logic        finished = 1'b0;

    function automatic logic [31:0] pat(input logic [15:0] s, input logic [15:0] a, input logic [7:0] lo);
        if (a == 16'd2) return {s, 8'h00, lo};
        return {s, a};
    endfunction

    // configuration memory model: reads are pattern-generated, writes are logged
    always @(posedge clk) begin
        if (cfg_rd) begin
            cfg_rdata <= pat(seed, cfg_addr, iq_lo);
            rd_log[rd_cnt % 1024] = cfg_addr;
            rd_cnt = rd_cnt + 1;
        end
        if (cfg_wr) begin
            wmem[cfg_addr[7:0]] = cfg_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if ((cfg_rd || cfg_wr) && cfg_addr >= 16'd256) oob_cnt = oob_cnt + 1;
        if (ack_post) ack_cnt = ack_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // issue an action, count busy cycles, wait until idle
    task automatic do_action(input logic [31:0] w, output int busy_cycles);
        @(negedge clk);
        act_wr = 1'b1;
        act_wdata = w;
        @(negedge clk);
        act_wr = 1'b0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles = busy_cycles + 1;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ts_all(input string req, input logic [15:0] s);
        int bad = 0;
        for (int i = 0; i < 32; i++) begin
            ts_sel = 5'(i);
            #1;
            if (ts_word !== pat(s, 16'(3 + i), 8'h00)) begin
                bad = bad + 1;
                if (bad == 1) $display("FAIL %s: ts %0d actual 0x%08h expected 0x%08h",
                                       req, i, ts_word, pat(s, 16'(3 + i), 8'h00));
            end
        end
        n_chk = n_chk + 1;
        if (bad != 0) n_bad = n_bad + 1;
    endtask

    task automatic chk_ch(input string req, input int c, input logic [15:0] s);
        logic [15:0] b;
        b = 16'(35 + 4 * c);
        ch_sel = 5'(c);
        #1;
        chk(req, ch_status,   pat(s, b,         8'h00));
        chk(req, ch_rx_first, pat(s, b + 16'd1, 8'h00));
        chk(req, ch_tx_first, pat(s, b + 16'd2, 8'h00));
        chk(req, ch_bufsz,    pat(s, b + 16'd3, 8'h00));
        chk(req, ch_rx_cur,   pat(s, b + 16'd1, 8'h00));
        chk(req, ch_tx_cur,   pat(s, b + 16'd2, 8'h00));
        chk(req, wmem[8'(195 + c)], pat(s, b + 16'd2, 8'h00));
    endtask

    task automatic chk_ch_all(input string req, input logic [15:0] s);
        int bad0;
        bad0 = n_bad;
        for (int c = 0; c < 32; c++) chk_ch(req, c, s);
        if (n_bad != bad0) $display("FAIL %s: channel sweep had %0d mismatches (expected 0)", req, n_bad - bad0);
    endtask

    task automatic t_reset;
        chk("R9 reset busy", 32'(busy), 32'd0);
        chk("R7 reset ack", 32'(ack_post), 32'd0);
        chk("R1 reset len", 32'(iq_len), 32'd0);
        ts_sel = 5'd0; ch_sel = 5'd0; #1;
        chk("R2 reset ts", ts_word, 32'd0);
        chk("R5 reset ch", ch_tx_cur, 32'd0);
    endtask

    task automatic t_iq_only;
        int bc, r0, w0, a0;
        seed = 16'h1111; iq_lo = 8'h07;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_0004, bc);
        chk("R9 busy cycles iq", 32'(bc), 32'd3);
        chk("R1 base", iq_base, pat(16'h1111, 16'd1, 8'h07));
        chk("R1 cur", iq_cur, pat(16'h1111, 16'd1, 8'h07));
        chk("R1 len 128", 32'(iq_len), 32'd128);
        chk("R1 reads", 32'(rd_cnt - r0), 32'd2);
        chk("R6 no writes", 32'(wr_cnt - w0), 32'd0);
        chk("R7 no ack for queue only", 32'(ack_cnt - a0), 32'd0);
        ts_sel = 5'd0; #1;
        chk("R1 ts untouched", ts_word, 32'd0);
    endtask

    task automatic t_iq_init;
        int bc, r0, w0, a0;
        seed = 16'h2222; iq_lo = 8'hFF;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_8904, bc);
        chk("R8 first read", 32'(rd_log[r0 % 1024]), 32'd1);
        chk("R8 second read", 32'(rd_log[(r0 + 1) % 1024]), 32'd2);
        chk("R8 third read is ts", 32'(rd_log[(r0 + 2) % 1024]), 32'd3);
        chk("R1 len 4096", 32'(iq_len), 32'd4096);
        chk("R2 reads", 32'(rd_cnt - r0), 32'd38);
        chk_ts_all("R2 ts reload", 16'h2222);
        chk_ch("R5 ch9", 9, 16'h2222);
        ch_sel = 5'd8; #1;
        chk("R2 ch8 untouched", ch_status, 32'd0);
        chk("R6 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R7 one ack", 32'(ack_cnt - a0), 32'd1);
        chk("R9 busy cycles", 32'(bc), 32'd40);
    endtask

    task automatic t_chan_only_masked;
        int bc, r0, w0, a0;
        seed = 16'h3333;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_5F80, bc);
        chk_ts_all("R3 ts kept", 16'h2222);
        chk_ch("R3 ch31", 31, 16'h3333);
        chk_ch("R3 ch9 kept", 9, 16'h2222);
        chk("R3 reads", 32'(rd_cnt - r0), 32'd4);
        chk("R6 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R7 masked no ack", 32'(ack_cnt - a0), 32'd0);
    endtask

    task automatic t_reset_all_with_intruder;
        int bc, r0, w0, a0;
        seed = 16'h4444;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        @(negedge clk);
        act_wr = 1'b1; act_wdata = 32'h0000_0040;
        @(negedge clk);
        act_wr = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 busy mid run", 32'(busy), 32'd1);
        act_wr = 1'b1; act_wdata = 32'h0000_4300;
        @(negedge clk);
        act_wr = 1'b0;
        bc = 0;
        while (busy) begin bc = bc + 1; @(negedge clk); end
        repeat (2) @(negedge clk);
        chk_ts_all("R4 ts", 16'h4444);
        chk_ch_all("R4 channels", 16'h4444);
        chk("R4 reads", 32'(rd_cnt - r0), 32'd160);
        chk("R6 writes", 32'(wr_cnt - w0), 32'd32);
        chk("R9 intruder dropped ack", 32'(ack_cnt - a0), 32'd1);
    endtask

    task automatic t_illegal;
        int bc, r0, w0, a0;
        seed = 16'h5555;
        w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_4240, bc);
        chk_ch_all("R10 reset over chan-only", 16'h5555);
        chk("R10 writes", 32'(wr_cnt - w0), 32'd32);
        chk("R10 one ack", 32'(ack_cnt - a0), 32'd1);
        seed = 16'h6666;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_C400, bc);
        chk_ts_all("R10 init over chan-only ts", 16'h6666);
        chk_ch("R10 ch4", 4, 16'h6666);
        chk_ch("R10 ch5 kept", 5, 16'h5555);
        chk("R10 reads", 32'(rd_cnt - r0), 32'd36);
        chk("R10 one write", 32'(wr_cnt - w0), 32'd1);
        chk("R10 ack", 32'(ack_cnt - a0), 32'd1);
    endtask

    task automatic t_noop;
        int bc, r0, w0, a0;
        r0 = rd_cnt; w0 = wr_cnt; a0 = ack_cnt;
        do_action(32'h0000_0000, bc);
        chk("R9 noop busy", 32'(bc), 32'd1);
        chk("R9 noop reads", 32'(rd_cnt - r0), 32'd0);
        chk("R9 noop writes", 32'(wr_cnt - w0), 32'd0);
        chk("R9 noop ack", 32'(ack_cnt - a0), 32'd0);
        chk("R9 oob accesses", 32'(oob_cnt), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) wmem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_iq_only();
        t_iq_init();
        t_chan_only_masked();
        t_reset_all_with_intruder();
        t_illegal();
        t_noop();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule